// File: doc/BRIEF.md
# Four-State Shared Bus Resolver

This block merges the values placed on a shared bus by several drivers into one resolved value per bus bit. Each driver presents a 2-bit state code for every bit. The codes follow a four-state logic system: undefined, logic 0, logic 1 and high impedance. The block is purely combinational, so the resolved value and a per-bit conflict flag follow the driver codes in the same cycle.

For each bit, the block starts from driver 0 and folds in every later driver one at a time. A driver at high impedance takes no part in the result. An undefined driver forces the result to undefined. Two active drivers that disagree also produce an undefined result. The number of drivers and the bus width are parameters. The single-bit resolver is replicated once per bus bit.

Top module: `bus_vec_resolver`

## Requirements
- R1: Each state uses a fixed 2-bit code: undefined = 0, logic 0 = 1, logic 1 = 2, high impedance = 3. Every input and output code uses this encoding.
- R2: When any driver of a bit presents the undefined code, the resolved value of that bit is undefined (code 0).
- R3: A driver at high impedance (code 3) has no effect. Changing any driver between high impedance and the value every other active driver already shows leaves both the resolved value and the conflict flag of that bit unchanged.
- R4: When one active driver of a bit shows logic 0 and another shows logic 1, the resolved value of that bit is undefined.
- R5: When every driver of a bit is at high impedance, the resolved value of that bit is high impedance (code 3).
- R6: When all non-high-impedance drivers of a bit show the same defined value (0 or 1), the resolved value of that bit is that value.
- R7: The conflict flag of a bit is 1 exactly when the driver count exceeds 1 and the resolved value of that bit is undefined. Otherwise it is 0.
- R8: With a driver count of 1, each output bit equals the code of the single driver, and the conflict flag is always 0.
- R9: Bus bits resolve independently. The codes on one bit have no effect on another bit. The output settles in the same cycle in which the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| drv_i | input | NUM_DRV*BUS_W*2 | Packed driver codes: drv_i[d][b] is the 2-bit code that driver d places on bit b |
| res_o | output | BUS_W*2 | Resolved 2-bit code for each bus bit |
| conflict_o | output | BUS_W | Per-bit conflict flag |

## Verification
A faulty merge stage or a broken fold chain shows up at res_o in the same cycle that the offending driver pattern arrives. The block has no state, so an error cannot hide and surface later. Because of this, every cycle compares the full bus against a reference that only counts undefined, 0 and 1 drivers. Directed patterns aim at the cases a single wrong merge rule would spoil: undefined against high impedance, 0 against 1 with high impedance in between, all drivers at high impedance, and a lone active driver at the last position. A wrong conflict qualifier appears at conflict_o in the same cycle, and the single-driver build exposes a flag that should never rise.

// File: rtl/bus_res_pkg.sv
package bus_res_pkg;

    // State codes; the order is part of the behaviour (R1)
    typedef enum logic [1:0] {
        ST_UNDEF = 2'd0,
        ST_ZERO  = 2'd1,
        ST_ONE   = 2'd2,
        ST_HIZ   = 2'd3
    } bus_state_e;

    typedef struct packed {
        bus_state_e value;
        logic       conflict;
    } bit_result_t;

    // Merge an accumulated value with one more driver
    function automatic bus_state_e merge_pair(input bus_state_e acc, input bus_state_e nxt);
        bus_state_e r;
        unique case (nxt)
            ST_HIZ:   r = acc;
            ST_UNDEF: r = ST_UNDEF;
            default: begin
                if (acc == ST_HIZ)      r = nxt;
                else if (acc == nxt)    r = acc;
                else                    r = ST_UNDEF;
            end
        endcase
        return r;
    endfunction

    function automatic logic is_active(input bus_state_e s);
        return (s == ST_ZERO) || (s == ST_ONE);
    endfunction

endpackage

// File: rtl/bus_pair_merge.sv
module bus_pair_merge
    import bus_res_pkg::*;
(
    input  bus_state_e acc_i,
    input  bus_state_e nxt_i,
    output bus_state_e y_o
);

    always_comb begin
        y_o = merge_pair(acc_i, nxt_i);
    end

    always_comb begin
        // R3
        hiz_transparent_chk: assert (nxt_i != ST_HIZ || y_o == acc_i)
            else $error("high impedance driver altered merge result");
        // R2
        undef_dominates_chk: assert (!(nxt_i == ST_UNDEF || acc_i == ST_UNDEF) || y_o == ST_UNDEF)
            else $error("undefined input did not dominate");
    end

endmodule

// File: rtl/bus_bit_resolver.sv
module bus_bit_resolver
    import bus_res_pkg::*;
#(
    parameter int NUM_DRV = 4
) (
    input  bus_state_e  drv_i [NUM_DRV],
    output bit_result_t res_o
);

    bus_state_e chain [NUM_DRV];

    assign chain[0] = drv_i[0];

    generate
        for (genvar i = 1; i < NUM_DRV; i++) begin : g_fold
            bus_pair_merge u_merge (
                .acc_i (chain[i-1]),
                .nxt_i (drv_i[i]),
                .y_o   (chain[i])
            );
        end

        if (NUM_DRV > 1) begin : g_multi
            assign res_o.conflict = (chain[NUM_DRV-1] == ST_UNDEF);
        end else begin : g_single
            assign res_o.conflict = 1'b0;
            always_comb begin
                // R8
                single_copy_chk: assert (res_o.value == drv_i[0])
                    else $error("single driver not copied");
            end
        end
    endgenerate

    assign res_o.value = chain[NUM_DRV-1];

    // Independent summaries of the driver set for checking
    logic saw_zero, saw_one, saw_undef, all_hiz;
    always_comb begin
        saw_zero  = 1'b0;
        saw_one   = 1'b0;
        saw_undef = 1'b0;
        all_hiz   = 1'b1;
        for (int k = 0; k < NUM_DRV; k++) begin
            if (drv_i[k] == ST_ZERO)  saw_zero  = 1'b1;
            if (drv_i[k] == ST_ONE)   saw_one   = 1'b1;
            if (drv_i[k] == ST_UNDEF) saw_undef = 1'b1;
            if (is_active(drv_i[k]) || drv_i[k] == ST_UNDEF) all_hiz = 1'b0;
        end
    end

    always_comb begin
        // R4
        disagree_undef_chk: assert (!(saw_zero && saw_one) || res_o.value == ST_UNDEF)
            else $error("0/1 disagreement not undefined");
        // R5
        all_hiz_chk: assert (!all_hiz || res_o.value == ST_HIZ)
            else $error("all high impedance not preserved");
        // R7
        conflict_flag_chk: assert (res_o.conflict == ((NUM_DRV > 1) && (saw_undef || (saw_zero && saw_one))))
            else $error("conflict flag mismatch");
    end

endmodule

// File: rtl/bus_vec_resolver.sv
module bus_vec_resolver
    import bus_res_pkg::*;
#(
    parameter int NUM_DRV = 4,
    parameter int BUS_W   = 8
) (
    input  logic [NUM_DRV-1:0][BUS_W-1:0][1:0] drv_i,
    output logic [BUS_W-1:0][1:0]              res_o,
    output logic [BUS_W-1:0]                   conflict_o
);

    generate
        for (genvar b = 0; b < BUS_W; b++) begin : g_bit
            bus_state_e  col [NUM_DRV];
            bit_result_t rb;

            for (genvar d = 0; d < NUM_DRV; d++) begin : g_col
                assign col[d] = bus_state_e'(drv_i[d][b]);
            end

            bus_bit_resolver #(.NUM_DRV(NUM_DRV)) u_bit (
                .drv_i (col),
                .res_o (rb)
            );

            assign res_o[b]      = rb.value;
            assign conflict_o[b] = rb.conflict;
        end
    endgenerate

endmodule

// File: tb/tb_bus_vec_resolver.sv
module tb_bus_vec_resolver;

    localparam int ND = 4;
    localparam int BW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [ND-1:0][BW-1:0][1:0] drv;
    logic [BW-1:0][1:0]         res;
    logic [BW-1:0]              cfl;

    logic [0:0][1:0][1:0]       drv1;
    logic [1:0][1:0]            res1;
    logic [1:0]                 cfl1;

    int n_checks = 0;
    int n_fail   = 0;

    bus_vec_resolver #(.NUM_DRV(ND), .BUS_W(BW)) dut (
        .drv_i (drv), .res_o (res), .conflict_o (cfl));

    bus_vec_resolver #(.NUM_DRV(1), .BUS_W(2)) dut_one (
        .drv_i (drv1), .res_o (res1), .conflict_o (cfl1));

    // Reference by counting: 0=undef 1=zero 2=one 3=hiz (R1)
    function automatic void ref_vec(input logic [ND-1:0][BW-1:0][1:0] d,
                                    output logic [BW-1:0][1:0] r,
                                    output logic [BW-1:0] c);
        for (int b = 0; b < BW; b++) begin
            int nx = 0, n0 = 0, n1 = 0;
            for (int k = 0; k < ND; k++) begin
                if (d[k][b] == 2'd0) nx++;
                else if (d[k][b] == 2'd1) n0++;
                else if (d[k][b] == 2'd2) n1++;
            end
            if (nx > 0 || (n0 > 0 && n1 > 0)) r[b] = 2'd0;
            else if (n0 > 0) r[b] = 2'd1;
            else if (n1 > 0) r[b] = 2'd2;
            else r[b] = 2'd3;
            c[b] = (ND > 1) && (r[b] == 2'd0);
        end
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_main(input string req);
        logic [BW-1:0][1:0] er;
        logic [BW-1:0]      ec;
        ref_vec(drv, er, ec);
        check({req, " value"}, 32'(res), 32'(er));
        check({req, " conflict"}, 32'(cfl), 32'(ec));
    endtask

    // Every bit of driver k gets code c[k]
    task automatic apply_uniform(input logic [1:0] c0, input logic [1:0] c1,
                                 input logic [1:0] c2, input logic [1:0] c3);
        @(posedge clk);
        for (int b = 0; b < BW; b++) begin
            drv[0][b] = c0; drv[1][b] = c1; drv[2][b] = c2; drv[3][b] = c3;
        end
        @(negedge clk);
    endtask

    initial begin
        #1000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [BW-1:0][1:0] snap_r;
        logic [BW-1:0]      snap_c;
        drv  = '1;
        drv1 = '1;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset-time state: all high impedance (R5)
        check("R5 idle", 32'(res), 32'hFFFF);
        check("R7 idle", 32'(cfl), 32'h0);

        apply_uniform(2'd0, 2'd3, 2'd3, 2'd3); check_main("R2 undef vs hiz");
        check("R2 direct", 32'(res), 32'h0);
        apply_uniform(2'd2, 2'd2, 2'd0, 2'd2); check_main("R2 undef among ones");
        apply_uniform(2'd1, 2'd3, 2'd3, 2'd2); check_main("R4 zero/one");
        check("R4 direct", 32'(res), 32'h0);
        check("R7 direct", 32'(cfl), 32'hFF);
        apply_uniform(2'd3, 2'd3, 2'd3, 2'd3); check_main("R5 all hiz");
        apply_uniform(2'd3, 2'd3, 2'd3, 2'd2); check_main("R6 last active");
        check("R6 direct", 32'(res), 32'hAAAA);
        apply_uniform(2'd1, 2'd1, 2'd3, 2'd1); check_main("R6 zeros agree");
        check("R7 agree no flag", 32'(cfl), 32'h0);

        // R3: swap agreeing drivers to hiz, outputs must not move
        apply_uniform(2'd2, 2'd2, 2'd2, 2'd2);
        snap_r = res; snap_c = cfl;
        apply_uniform(2'd2, 2'd3, 2'd3, 2'd2);
        check("R3 hiz value", 32'(res), 32'(snap_r));
        check("R3 hiz conflict", 32'(cfl), 32'(snap_c));

        // R9: per-bit independent patterns
        @(posedge clk);
        for (int b = 0; b < BW; b++)
            for (int k = 0; k < ND; k++)
                drv[k][b] = 2'((b + k * (b + 1)) % 4);
        @(negedge clk);
        check_main("R9 per bit");

        // R8: single-driver instance
        for (int v = 0; v < 16; v++) begin
            @(posedge clk);
            drv1 = 4'(v);
            @(negedge clk);
            check("R8 copy", 32'(res1), 32'(v));
            check("R8 no flag", 32'(cfl1), 32'h0);
        end

        // Random sweep compared each cycle (R1 R2 R4 R6 R7 R9)
        for (int t = 0; t < 3000; t++) begin
            @(posedge clk);
            drv = (ND * BW * 2)'({$urandom, $urandom});
            if (t % 3 == 0)
                for (int b = 0; b < BW; b++) drv[$urandom % ND][b] = 2'd3;
            @(negedge clk);
            check_main("R1 sweep");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule